// File: doc/BRIEF.md
# ModR/M Effective Address Generator

This block sits behind the opcode fetch of an instruction decoder. After a one-byte opcode has been taken, the bytes that follow are offered to it one per cycle over a valid/ready handshake. The first byte is the ModR/M byte, split into a 2-bit mode, a 3-bit register field and a 3-bit r/m field. Depending on the mode and r/m, the block then gathers zero, one or four displacement bytes and forms a 32-bit memory effective address.

While the ModR/M byte is on the input, the block drives a read address to an external eight-entry register file. It samples the returned base value in that same cycle. When the address is complete, it raises `done` for one cycle along with the address, the untouched register field and the number of bytes it consumed. Forms it does not handle, namely a scaled-index byte (r/m 100) and register-direct mode (mod 11), finish at once with an `unsupported` flag instead of an address.

Top module: `modrmAddrGen`

## Requirements
- R1: At `done`, `regField` equals bits 5:3 of the ModR/M byte of that instruction, for every mode including unsupported ones.
- R2: Mode 00 with r/m neither 100 nor 101 gives `effAddr` equal to the register selected by r/m (bits 2:0), reads no further bytes and reports `bytesUsed` = 1.
- R3: Mode 00 with r/m 101 ignores the register file and takes the next four bytes, least significant first, as the absolute address; `bytesUsed` = 5.
- R4: Mode 01 reads one more byte, sign-extends it to 32 bits and adds it to the r/m register (r/m 101 selects a register here too); `bytesUsed` = 2.
- R5: Mode 10 reads four more bytes, least significant first, and adds them to the r/m register; `bytesUsed` = 5.
- R6: Mode 11 (bits 7:6 = 11), or r/m 100 in any other mode, finishes right after the ModR/M byte with `unsupported` = 1, `effAddr` = 0 and `bytesUsed` = 1, consuming no displacement bytes.
- R7: The address sum wraps modulo 2^32.
- R8: A byte is taken only on a clock edge where `byteValid` and `byteReady` are both high. `done` is a single-cycle pulse that follows the edge that took the last byte, and `byteReady` is low exactly during that pulse, so a byte offered then is not consumed.
- R9: Reset clears `done` and `unsupported`, raises `byteReady` and drops any partly gathered instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | An instruction byte is offered |
| byteData | input | 8 | Offered instruction byte |
| byteReady | output | 1 | Block can take a byte this cycle |
| regIdx | output | 3 | Register file read address (r/m bits of the offered byte) |
| regData | input | ADDR_W | Register file read data for `regIdx` |
| effAddr | output | ADDR_W | Effective address, valid with `done` |
| regField | output | 3 | Register field of the ModR/M byte, valid with `done` |
| bytesUsed | output | 3 | Bytes consumed including ModR/M, valid with `done` |
| unsupported | output | 1 | Form not handled, valid with `done` |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with its default 32-bit address width, so a long displacement is four bytes and the sum wraps at 2^32. That makes the all-ones displacement that subtracts one, the carry out of 0xFFFFFFFF and the step from 0x7FFFFFFF to 0x80000000 reachable with real register values. The register file model holds a distinct value in r/m 5, so an absolute-address result proves the register was ignored. Stalls between displacement bytes, a byte held during the done cycle and a reset in the middle of an instruction exercise the handshake and the restart.

// File: rtl/modrm_pkg.sv
package modrm_pkg;

  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 3;

  localparam logic [1:0] MODE_IND    = 2'b00;
  localparam logic [1:0] MODE_DISP8  = 2'b01;
  localparam logic [1:0] MODE_DIRECT = 2'b11;
  localparam logic [2:0] RM_SIB      = 3'b100;
  localparam logic [2:0] RM_ABS      = 3'b101;

  typedef enum logic [2:0] {
    FIN_NONE,
    FIN_DIRECT,
    FIN_DISP8,
    FIN_DISP32,
    FIN_UNSUP
  } finish_e;

  typedef struct packed {
    logic    takeModrm;
    logic    zeroBase;
    logic    takeDisp;
    finish_e finish;
  } ctrlStrobes_t;

endpackage

// File: rtl/modrmCtrl.sv
module modrmCtrl
  import modrm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output logic              byteReady,
  output ctrlStrobes_t      strobes
);

  localparam int DISP_BYTES = ADDR_W / BYTE_W;
  localparam int LEFT_W     = $clog2(DISP_BYTES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DISP, ST_DONE} state_e;

  state_e            stateQ, stateD;
  logic [LEFT_W-1:0] leftQ, leftD;
  logic              shortQ, shortD;
  logic [1:0]        modeIn;
  logic [2:0]        rmIn;

  assign modeIn    = byteData[7:6];
  assign rmIn      = byteData[2:0];
  assign byteReady = (stateQ != ST_DONE);

  always_comb begin
    strobes = '{takeModrm: 1'b0, zeroBase: 1'b0, takeDisp: 1'b0, finish: FIN_NONE};
    stateD  = stateQ;
    leftD   = leftQ;
    shortD  = shortQ;
    case (stateQ)
      ST_IDLE: begin
        if (byteValid) begin
          if (modeIn == MODE_DIRECT || rmIn == RM_SIB) begin
            strobes.finish = FIN_UNSUP;
            stateD         = ST_DONE;
          end else if (modeIn == MODE_IND && rmIn != RM_ABS) begin
            strobes.finish = FIN_DIRECT;
            stateD         = ST_DONE;
          end else begin
            strobes.takeModrm = 1'b1;
            strobes.zeroBase  = (modeIn == MODE_IND);
            shortD            = (modeIn == MODE_DISP8);
            leftD             = (modeIn == MODE_DISP8) ? LEFT_W'(1) : LEFT_W'(DISP_BYTES);
            stateD            = ST_DISP;
          end
        end
      end
      ST_DISP: begin
        if (byteValid) begin
          if (leftQ == LEFT_W'(1)) begin
            strobes.finish = shortQ ? FIN_DISP8 : FIN_DISP32;
            stateD         = ST_DONE;
          end else begin
            strobes.takeDisp = 1'b1;
            leftD            = leftQ - LEFT_W'(1);
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      leftQ  <= '0;
      shortQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      leftQ  <= leftD;
      shortQ <= shortD;
    end
  end

endmodule

// File: rtl/modrmDatapath.sv
module modrmDatapath
  import modrm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [ADDR_W-1:0] regData,
  input  ctrlStrobes_t      strobes,
  output logic [ADDR_W-1:0] effAddr,
  output logic [IDX_W-1:0]  regField,
  output logic [2:0]        bytesUsed,
  output logic              unsupported,
  output logic              done
);

  logic [ADDR_W-1:0] baseQ, dispQ, dispNext, dispShort;
  logic [2:0]        cntQ;
  logic [IDX_W-1:0]  regHoldQ;

  assign dispNext  = {byteData, dispQ[ADDR_W-1:BYTE_W]};
  assign dispShort = {{(ADDR_W-BYTE_W){byteData[BYTE_W-1]}}, byteData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ       <= '0;
      dispQ       <= '0;
      cntQ        <= '0;
      regHoldQ    <= '0;
      effAddr     <= '0;
      regField    <= '0;
      bytesUsed   <= '0;
      unsupported <= 1'b0;
      done        <= 1'b0;
    end else begin
      if (strobes.takeModrm) begin
        baseQ    <= strobes.zeroBase ? '0 : regData;
        dispQ    <= '0;
        cntQ     <= 3'd1;
        regHoldQ <= byteData[5:3];
      end
      if (strobes.takeDisp) begin
        dispQ <= dispNext;
        cntQ  <= cntQ + 3'd1;
      end
      done        <= (strobes.finish != FIN_NONE);
      unsupported <= (strobes.finish == FIN_UNSUP);
      case (strobes.finish)
        FIN_DIRECT: begin
          effAddr   <= regData;
          regField  <= byteData[5:3];
          bytesUsed <= 3'd1;
        end
        FIN_UNSUP: begin
          effAddr   <= '0;
          regField  <= byteData[5:3];
          bytesUsed <= 3'd1;
        end
        FIN_DISP8: begin
          effAddr   <= baseQ + dispShort;
          regField  <= regHoldQ;
          bytesUsed <= cntQ + 3'd1;
        end
        FIN_DISP32: begin
          effAddr   <= baseQ + dispNext;
          regField  <= regHoldQ;
          bytesUsed <= cntQ + 3'd1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/modrmAddrGen.sv
module modrmAddrGen
  import modrm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  output logic              byteReady,
  output logic [2:0]        regIdx,
  input  logic [ADDR_W-1:0] regData,
  output logic [ADDR_W-1:0] effAddr,
  output logic [2:0]        regField,
  output logic [2:0]        bytesUsed,
  output logic              unsupported,
  output logic              done
);

  ctrlStrobes_t strobes;

  assign regIdx = byteData[2:0];

  modrmCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteData  (byteData),
    .byteReady (byteReady),
    .strobes   (strobes)
  );

  modrmDatapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .byteData    (byteData),
    .regData     (regData),
    .strobes     (strobes),
    .effAddr     (effAddr),
    .regField    (regField),
    .bytesUsed   (bytesUsed),
    .unsupported (unsupported),
    .done        (done)
  );

endmodule

// File: rtl/modrmAddrGenChk.sv
module modrmAddrGenChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input logic              byteReady,
  input logic [ADDR_W-1:0] effAddr,
  input logic [2:0]        bytesUsed,
  input logic              unsupported,
  input logic              done
);

  localparam int LONG_USED = ADDR_W / 8 + 1;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  ready_low_in_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !byteReady);

  // R8
  done_after_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(byteValid && byteReady));

  // R6
  unsup_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && unsupported) |-> (effAddr == '0 && bytesUsed == 3'd1));

  // R6
  unsup_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    unsupported |-> done);

  // R2
  used_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (bytesUsed == 3'd1 || bytesUsed == 3'd2 || bytesUsed == 3'(LONG_USED)));

endmodule

bind modrmAddrGen modrmAddrGenChk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .byteValid   (byteValid),
  .byteReady   (byteReady),
  .effAddr     (effAddr),
  .bytesUsed   (bytesUsed),
  .unsupported (unsupported),
  .done        (done)
);

// File: tb/modrmAddrGen_tb_top.sv
module modrmAddrGen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int NVEC       = 14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              byteValid = 1'b0;
  logic [7:0]        byteData = 8'h00;
  logic              byteReady;
  logic [2:0]        regIdx;
  logic [ADDR_W-1:0] regData;
  logic [ADDR_W-1:0] effAddr;
  logic [2:0]        regField;
  logic [2:0]        bytesUsed;
  logic              unsupported;
  logic              done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] regFile [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign regData = regFile[regIdx];

  modrmAddrGen #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .regIdx(regIdx), .regData(regData),
    .effAddr(effAddr), .regField(regField), .bytesUsed(bytesUsed),
    .unsupported(unsupported), .done(done)
  );

  // bytes, first byte in bits 7:0
  localparam logic [39:0] V_BYTES [NVEC] = '{
    40'h0000000018, 40'h000000601d, 40'h000000ff59, 40'h000000025a,
    40'h000000029a, 40'hffffffff99, 40'h000000001e, 40'h0000000146,
    40'h0000000187, 40'h000000001c, 40'h00000000d8, 40'h0000007f45,
    40'h000000005c, 40'h000000003f };
  localparam int V_LEN [NVEC] = '{1, 5, 2, 2, 5, 5, 1, 2, 5, 1, 1, 2, 1, 1};
  localparam logic [31:0] V_ADDR [NVEC] = '{
    32'h60, 32'h60, 32'h60, 32'h60, 32'h60, 32'h60, 32'hffffffff, 32'h0,
    32'h80000000, 32'h0, 32'h0, 32'h8000007f, 32'h0, 32'h7fffffff };
  localparam logic [2:0] V_REG  [NVEC] = '{3, 3, 3, 3, 3, 3, 3, 0, 0, 3, 3, 0, 3, 7};
  localparam logic [2:0] V_USED [NVEC] = '{1, 5, 2, 2, 5, 5, 1, 2, 5, 1, 1, 2, 1, 1};
  localparam bit         V_UNS  [NVEC] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 0};
  localparam string      V_REQ  [NVEC] = '{
    "R2", "R3", "R4", "R4", "R5", "R5", "R2", "R7", "R7", "R6", "R6", "R4", "R6", "R2" };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drives the bytes, returns at the negedge right after the last byte was taken
  task automatic runInstr(input logic [39:0] bytes, input int len, input int gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while (!byteReady) @(negedge clk);
      byteValid = 1'b1;
      byteData  = bytes[8*i +: 8];
      if (gap > 0 && i < len - 1) begin
        @(negedge clk);
        byteValid = 1'b0;
        byteData  = 8'hd8;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic checkResult(input string req, input logic [31:0] addr, input logic [2:0] rf,
                             input logic [2:0] used, input bit uns);
    check(req, {31'b0, done}, 32'd1);
    check(req, effAddr, addr);
    check("R1", {29'b0, regField}, {29'b0, rf});
    check(req, {29'b0, bytesUsed}, {29'b0, used});
    check("R6", {31'b0, unsupported}, {31'b0, uns});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    regFile[0] = 32'h00000060; regFile[1] = 32'h00000061;
    regFile[2] = 32'h0000005e; regFile[3] = 32'h00000010;
    regFile[4] = 32'h00000044; regFile[5] = 32'h80000000;
    regFile[6] = 32'hffffffff; regFile[7] = 32'h7fffffff;

    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", {31'b0, done}, 32'd0);
    check("R9", {31'b0, unsupported}, 32'd0);
    check("R9", {31'b0, byteReady}, 32'd1);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      runInstr(V_BYTES[v], V_LEN[v], 0);
      checkResult(V_REQ[v], V_ADDR[v], V_REG[v], V_USED[v], V_UNS[v]);
    end

    // R8 stalls between displacement bytes must not change the result
    runInstr(40'h000000029a, 5, 3);
    checkResult("R8", 32'h60, 3'd3, 3'd5, 1'b0);

    // R8 done lasts one cycle and a byte offered during it is not taken
    runInstr(40'h0000000018, 1, 0);
    check("R8", {31'b0, byteReady}, 32'd0);
    byteValid = 1'b1;
    byteData  = 8'h59;
    @(negedge clk);
    byteValid = 1'b0;
    check("R8", {31'b0, done}, 32'd0);
    repeat (2) @(negedge clk);
    check("R8", {31'b0, done}, 32'd0);
    runInstr(40'h000000003f, 1, 0);
    checkResult("R8", 32'h7fffffff, 3'd7, 3'd1, 1'b0);

    // R9 reset in the middle of a long displacement drops it
    runInstr(40'h000000029a, 2, 0);
    rstN = 1'b0;
    @(negedge clk);
    check("R9", {31'b0, done}, 32'd0);
    check("R9", {31'b0, byteReady}, 32'd1);
    rstN = 1'b1;
    runInstr(40'h0000000018, 1, 0);
    checkResult("R9", 32'h60, 3'd3, 3'd1, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule